// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block translates 64-bit virtual addresses into physical addresses through a small, fully associative table. Every table slot covers two neighbouring virtual pages at once: one slot word describes the even page and one the odd page, and the address bit just above the in-page offset picks between them. Each slot carries its own page-size mask, so one table can hold 4 KB pages next to pages as large as 16 MB.

A request presents a virtual address, the current address-space identifier and a direction flag. One cycle later the block answers with either a physical address and a writable flag, or a fault code that tells a missing translation (refill), a present but invalid page, and a write to a clean page apart. Slots are loaded through a write port, and the most recently written slot is where the next search begins; the search wraps around the table and the first matching slot wins.

Segment decoding, exception dispatch and caching belong to the surrounding core.

Top module: `ptlb_lookup`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rsp_valid`, `rsp_ok` and `rsp_writable` are 0 and `rsp_fault` is 0; reset clears every slot field to zero, so a read of address 0 with identifier 0 reports fault code 3.
- R2: A request presented in one cycle is answered in the next cycle with `rsp_valid` = 1; a cycle without a request gives `rsp_valid` = 0. A slot written in the same cycle as a request is not seen by that request, only by later ones.
- R3: The virtual address bit at position (page shift) selects the odd half (bit = 1) or the even half (bit = 0) of a matching slot; frame, valid and dirty all come from the selected half.
- R4: A page mask of 0 gives a page shift of 12; a mask field (covering address bits 24..13) of 0x003, 0x00F, 0x03F, 0x0FF, 0x3FF or 0xFFF gives shifts 14 to 24. The page-pair comparison ignores the masked bits, and the physical address is the frame number shifted left by 12 ORed with the address bits below the page shift.
- R5: A slot whose mask is not one of the legal values in R4 never matches.
- R6: Address bits 63:62 must equal the slot's region field for a match.
- R7: A slot matches only if its identifier equals the request identifier or its global flag is set (the hi-word flag by default; the AND of both lo-half flags when `GLB_FROM_LO` is 1).
- R8: A match whose selected valid bit is 0 gives fault code 3 for a read and 4 for a write, with `rsp_ok` = 0 and `rsp_paddr` = 0.
- R9: A valid match on a write whose selected dirty bit is 0 gives fault code 5; a valid read gives `rsp_ok` = 1, fault 0, and `rsp_writable` equal to the dirty bit; a valid write to a dirty page gives `rsp_ok` = 1, `rsp_writable` = 1.
- R10: When no slot matches, the fault code is 1 for a read and 2 for a write.
- R11: When several slots match, the winner is the first in the order starting at the last written slot index and wrapping past the highest index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 64 | Virtual address |
| req_asid | input | ASID_W | Current address-space identifier |
| req_write | input | 1 | 1 = store access, 0 = load access |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | IDX_W | Slot index to write (values at or above ENTRIES are dropped) |
| wr_region | input | 2 | Region field, compared with address bits 63:62 |
| wr_vpair | input | VMAP_W-13 | Page-pair number, address bits VMAP_W-1..13 |
| wr_asid | input | ASID_W | Slot identifier |
| wr_hi_g | input | 1 | Global flag of the hi word |
| wr_mask | input | 12 | Page mask over address bits 24..13 |
| wr_lo0_pfn | input | PFN_W | Even-page frame number |
| wr_lo0_v | input | 1 | Even-page valid |
| wr_lo0_d | input | 1 | Even-page dirty (writable) |
| wr_lo0_g | input | 1 | Even-page global flag |
| wr_lo1_pfn | input | PFN_W | Odd-page frame number |
| wr_lo1_v | input | 1 | Odd-page valid |
| wr_lo1_d | input | 1 | Odd-page dirty (writable) |
| wr_lo1_g | input | 1 | Odd-page global flag |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_writable | output | 1 | Page may be written |
| rsp_paddr | output | PFN_W+12 | Physical address |
| rsp_fault | output | 3 | 0 none, 1 read refill, 2 write refill, 3 read invalid, 4 write invalid, 5 modify |

## Verification
The bench builds the block with ENTRIES = 6 and the other parameters at their defaults (8-bit identifier, 24-bit frame, 40 mapped address bits, global flag from the hi word). Six slots is not a power of two, so the wrap of the priority search from index 5 back to 0 is exercised on a non-trivial boundary, and it leaves room for slots with 4 KB, 16 KB and 16 MB pages, an illegal mask and two overlapping slots at the same time.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

  localparam int MASK_W    = 12;
  localparam int MIN_SHIFT = 12;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_REFILL_LD = 3'd1,
    FLT_REFILL_ST = 3'd2,
    FLT_INVAL_LD  = 3'd3,
    FLT_INVAL_ST  = 3'd4,
    FLT_MODIFY    = 3'd5
  } fault_e;

  // Legal masks are runs of ones from bit 0, in pairs.
  function automatic logic mask_legal(input logic [MASK_W-1:0] m);
    logic ok;
    ok = 1'b0;
    for (int k = 0; k <= MASK_W / 2; k++) begin
      if (m == MASK_W'((1 << (2 * k)) - 1)) ok = 1'b1;
    end
    return ok;
  endfunction

endpackage

// File: rtl/ptlb_match.sv
module ptlb_match
  import ptlb_pkg::*;
#(
  parameter int ASID_W      = 8,
  parameter int PFN_W       = 24,
  parameter int VMAP_W      = 40,
  parameter int GLB_FROM_LO = 0,
  localparam int VPAIR_W    = VMAP_W - MIN_SHIFT - 1,
  localparam int PA_W       = PFN_W + MIN_SHIFT,
  localparam int POS_W      = $clog2(VMAP_W)
) (
  input  logic [VMAP_W-1:0]  va,
  input  logic [1:0]         va_region,
  input  logic [ASID_W-1:0]  cur_asid,
  input  logic [1:0]         e_region,
  input  logic [VPAIR_W-1:0] e_vpair,
  input  logic [ASID_W-1:0]  e_asid,
  input  logic               e_hi_g,
  input  logic [MASK_W-1:0]  e_mask,
  input  logic [PFN_W-1:0]   e_lo0_pfn,
  input  logic               e_lo0_v,
  input  logic               e_lo0_d,
  input  logic               e_lo0_g,
  input  logic [PFN_W-1:0]   e_lo1_pfn,
  input  logic               e_lo1_v,
  input  logic               e_lo1_d,
  input  logic               e_lo1_g,
  output logic               hit,
  output logic               sel_valid,
  output logic               sel_dirty,
  output logic [PA_W-1:0]    paddr
);

  logic [VPAIR_W-1:0] ign;
  logic [3:0]         ones;
  logic [POS_W-1:0]   odd_pos;
  logic               odd, legal, vmatch, amatch, glob;
  logic [PA_W-1:0]    offm;
  logic [PFN_W-1:0]   pfn;
  logic               unused_glob;

  assign unused_glob = e_hi_g ^ e_lo0_g ^ e_lo1_g;

  always_comb begin
    ign     = VPAIR_W'(e_mask);
    legal   = mask_legal(e_mask);
    ones    = 4'($countones(e_mask));
    vmatch  = (((va[VMAP_W-1:MIN_SHIFT+1] ^ e_vpair) & ~ign) == '0) &&
              (va_region == e_region);
    glob    = (GLB_FROM_LO != 0) ? (e_lo0_g & e_lo1_g) : e_hi_g;
    amatch  = (e_asid == cur_asid) || glob;
    hit     = legal && vmatch && amatch;
    odd_pos = POS_W'(MIN_SHIFT) + POS_W'(ones);
    odd     = va[odd_pos];
    offm    = (PA_W'(1) << odd_pos) - PA_W'(1);
    pfn       = odd ? e_lo1_pfn : e_lo0_pfn;
    sel_valid = odd ? e_lo1_v   : e_lo0_v;
    sel_dirty = odd ? e_lo1_d   : e_lo0_d;
    paddr     = {pfn, {MIN_SHIFT{1'b0}}} | (va[PA_W-1:0] & offm);
  end

endmodule

// File: rtl/ptlb_pick.sv
module ptlb_pick #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] hits,
  input  logic [IDX_W-1:0]   start,
  output logic               any,
  output logic [IDX_W-1:0]   win
);

  logic [IDX_W:0] pos;

  always_comb begin
    any = 1'b0;
    win = '0;
    pos = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      pos = {1'b0, start} + (IDX_W+1)'(k);
      if (pos >= (IDX_W+1)'(ENTRIES)) pos = pos - (IDX_W+1)'(ENTRIES);
      if (!any && hits[pos[IDX_W-1:0]]) begin
        any = 1'b1;
        win = pos[IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/ptlb_lookup.sv
module ptlb_lookup
  import ptlb_pkg::*;
#(
  parameter int ENTRIES     = 8,
  parameter int ASID_W      = 8,
  parameter int PFN_W       = 24,
  parameter int VMAP_W      = 40,
  parameter int GLB_FROM_LO = 0,
  localparam int IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VPAIR_W    = VMAP_W - MIN_SHIFT - 1,
  localparam int PA_W       = PFN_W + MIN_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [63:0]        req_va,
  input  logic [ASID_W-1:0]  req_asid,
  input  logic               req_write,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [1:0]         wr_region,
  input  logic [VPAIR_W-1:0] wr_vpair,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic               wr_hi_g,
  input  logic [MASK_W-1:0]  wr_mask,
  input  logic [PFN_W-1:0]   wr_lo0_pfn,
  input  logic               wr_lo0_v,
  input  logic               wr_lo0_d,
  input  logic               wr_lo0_g,
  input  logic [PFN_W-1:0]   wr_lo1_pfn,
  input  logic               wr_lo1_v,
  input  logic               wr_lo1_d,
  input  logic               wr_lo1_g,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic               rsp_writable,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [2:0]         rsp_fault
);

  typedef struct packed {
    logic [1:0]         region;
    logic [VPAIR_W-1:0] vpair;
    logic [ASID_W-1:0]  asid;
    logic               g;
    logic [MASK_W-1:0]  mask;
  } hi_t;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             v;
    logic             d;
    logic             g;
  } lo_t;

  hi_t             hi_q  [ENTRIES];
  lo_t             lo0_q [ENTRIES];
  lo_t             lo1_q [ENTRIES];
  logic [IDX_W-1:0] last_q;

  logic             unused_va;
  assign unused_va = ^req_va[61:VMAP_W];

  // Slot storage and last-written index
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        hi_q[i]  <= '0;
        lo0_q[i] <= '0;
        lo1_q[i] <= '0;
      end
      last_q <= '0;
    end else if (wr_en && ({1'b0, wr_idx} < (IDX_W+1)'(ENTRIES))) begin
      hi_q[wr_idx]  <= '{region: wr_region, vpair: wr_vpair, asid: wr_asid,
                         g: wr_hi_g, mask: wr_mask};
      lo0_q[wr_idx] <= '{pfn: wr_lo0_pfn, v: wr_lo0_v, d: wr_lo0_d, g: wr_lo0_g};
      lo1_q[wr_idx] <= '{pfn: wr_lo1_pfn, v: wr_lo1_v, d: wr_lo1_d, g: wr_lo1_g};
      last_q        <= wr_idx;
    end
  end

  // Per-slot comparison
  logic [ENTRIES-1:0] hits, vbits, dbits;
  logic [PA_W-1:0]    pa_s [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    ptlb_match #(
      .ASID_W(ASID_W), .PFN_W(PFN_W), .VMAP_W(VMAP_W), .GLB_FROM_LO(GLB_FROM_LO)
    ) u_match (
      .va        (req_va[VMAP_W-1:0]),
      .va_region (req_va[63:62]),
      .cur_asid  (req_asid),
      .e_region  (hi_q[g].region),
      .e_vpair   (hi_q[g].vpair),
      .e_asid    (hi_q[g].asid),
      .e_hi_g    (hi_q[g].g),
      .e_mask    (hi_q[g].mask),
      .e_lo0_pfn (lo0_q[g].pfn),
      .e_lo0_v   (lo0_q[g].v),
      .e_lo0_d   (lo0_q[g].d),
      .e_lo0_g   (lo0_q[g].g),
      .e_lo1_pfn (lo1_q[g].pfn),
      .e_lo1_v   (lo1_q[g].v),
      .e_lo1_d   (lo1_q[g].d),
      .e_lo1_g   (lo1_q[g].g),
      .hit       (hits[g]),
      .sel_valid (vbits[g]),
      .sel_dirty (dbits[g]),
      .paddr     (pa_s[g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] win;

  ptlb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .hits  (hits),
    .start (last_q),
    .any   (any_hit),
    .win   (win)
  );

  // Fault classification
  fault_e          nxt_fault;
  logic            nxt_ok, nxt_wr;
  logic [PA_W-1:0] nxt_pa;

  always_comb begin
    nxt_ok    = 1'b0;
    nxt_wr    = 1'b0;
    nxt_pa    = '0;
    nxt_fault = FLT_NONE;
    if (!any_hit) begin
      nxt_fault = req_write ? FLT_REFILL_ST : FLT_REFILL_LD;
    end else if (!vbits[win]) begin
      nxt_fault = req_write ? FLT_INVAL_ST : FLT_INVAL_LD;
    end else if (req_write && !dbits[win]) begin
      nxt_fault = FLT_MODIFY;
    end else begin
      nxt_ok = 1'b1;
      nxt_wr = dbits[win];
      nxt_pa = pa_s[win];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_ok       <= 1'b0;
      rsp_writable <= 1'b0;
      rsp_paddr    <= '0;
      rsp_fault    <= FLT_NONE;
    end else begin
      rsp_valid    <= req_valid;
      rsp_ok       <= req_valid & nxt_ok;
      rsp_writable <= req_valid & nxt_wr;
      rsp_paddr    <= req_valid ? nxt_pa : '0;
      rsp_fault    <= req_valid ? nxt_fault : FLT_NONE;
    end
  end

endmodule

// File: rtl/ptlb_lookup_chk.sv
module ptlb_lookup_chk #(
  parameter int PA_W = 36
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_write,
  input logic            rsp_valid,
  input logic            rsp_ok,
  input logic            rsp_writable,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [2:0]      rsp_fault
);

  // R1: first cycle after reset carries no response
  p_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !rsp_ok && rsp_fault == 3'd0));

  // R2: one-cycle response latency
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R9: success carries no fault code; writable only on success
  p_ok_clean_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ok) |-> rsp_fault == 3'd0);

  p_writable_ok_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_writable |-> rsp_ok);

  // R8: a fault never carries an address
  p_fault_nopa_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ok) |-> (rsp_paddr == '0 && rsp_fault != 3'd0));

  // R10: fault codes stay in range and follow the access direction
  p_code_range_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_fault <= 3'd5);

  p_store_codes_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_write)) |-> (rsp_fault != 3'd1 && rsp_fault != 3'd3));

  p_load_codes_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(req_write)) |->
      (rsp_fault != 3'd2 && rsp_fault != 3'd4 && rsp_fault != 3'd5));

endmodule

bind ptlb_lookup ptlb_lookup_chk #(.PA_W(PA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .rsp_valid    (rsp_valid),
  .rsp_ok       (rsp_ok),
  .rsp_writable (rsp_writable),
  .rsp_paddr    (rsp_paddr),
  .rsp_fault    (rsp_fault)
);

// File: tb/ptlb_lookup_bench.sv
module ptlb_lookup_bench;

  localparam int ENTRIES = 6;
  localparam int IDX_W   = 3;
  localparam int ASID_W  = 8;
  localparam int PFN_W   = 24;
  localparam int VPAIR_W = 27;
  localparam int PA_W    = 36;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic [63:0]        req_va = '0;
  logic [ASID_W-1:0]  req_asid = '0;
  logic               req_write = 1'b0;
  logic               wr_en = 1'b0;
  logic [IDX_W-1:0]   wr_idx = '0;
  logic [1:0]         wr_region = '0;
  logic [VPAIR_W-1:0] wr_vpair = '0;
  logic [ASID_W-1:0]  wr_asid = '0;
  logic               wr_hi_g = 1'b0;
  logic [11:0]        wr_mask = '0;
  logic [PFN_W-1:0]   wr_lo0_pfn = '0;
  logic               wr_lo0_v = 1'b0, wr_lo0_d = 1'b0, wr_lo0_g = 1'b0;
  logic [PFN_W-1:0]   wr_lo1_pfn = '0;
  logic               wr_lo1_v = 1'b0, wr_lo1_d = 1'b0, wr_lo1_g = 1'b0;
  logic               rsp_valid, rsp_ok, rsp_writable;
  logic [PA_W-1:0]    rsp_paddr;
  logic [2:0]         rsp_fault;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ptlb_lookup #(.ENTRIES(ENTRIES)) u_ptlb_lookup (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_asid(req_asid), .req_write(req_write), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_region(wr_region), .wr_vpair(wr_vpair), .wr_asid(wr_asid),
    .wr_hi_g(wr_hi_g), .wr_mask(wr_mask),
    .wr_lo0_pfn(wr_lo0_pfn), .wr_lo0_v(wr_lo0_v), .wr_lo0_d(wr_lo0_d), .wr_lo0_g(wr_lo0_g),
    .wr_lo1_pfn(wr_lo1_pfn), .wr_lo1_v(wr_lo1_v), .wr_lo1_d(wr_lo1_d), .wr_lo1_g(wr_lo1_g),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_writable(rsp_writable),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic expect_rsp(input string rq, input logic ok, input logic wr,
                            input logic [PA_W-1:0] pa, input logic [2:0] flt);
    chk(rq, "valid", 64'(rsp_valid), 64'd1);
    chk(rq, "ok", 64'(rsp_ok), 64'(ok));
    chk(rq, "writable", 64'(rsp_writable), 64'(wr));
    chk(rq, "paddr", 64'(rsp_paddr), 64'(pa));
    chk(rq, "fault", 64'(rsp_fault), 64'(flt));
  endtask

  // Caller stands at a falling edge; one rising edge, then back to a falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic put_wr(input int idx, input logic [1:0] rg, input logic [VPAIR_W-1:0] vp,
                        input logic [7:0] asid, input logic hg, input logic [11:0] mask,
                        input logic [23:0] p0, input logic v0, input logic d0,
                        input logic [23:0] p1, input logic v1, input logic d1);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_region = rg; wr_vpair = vp;
    wr_asid = asid; wr_hi_g = hg; wr_mask = mask;
    wr_lo0_pfn = p0; wr_lo0_v = v0; wr_lo0_d = d0; wr_lo0_g = 1'b0;
    wr_lo1_pfn = p1; wr_lo1_v = v1; wr_lo1_d = d1; wr_lo1_g = 1'b0;
  endtask

  task automatic put_req(input logic [63:0] va, input logic [7:0] asid, input logic wr);
    req_valid = 1'b1; req_va = va; req_asid = asid; req_write = wr;
  endtask

  task automatic look(input logic [63:0] va, input logic [7:0] asid, input logic wr);
    put_req(va, asid, wr);
    step();
  endtask

  task automatic t_reset();
    chk("R1", "valid", 64'(rsp_valid), 64'd0);
    chk("R1", "ok", 64'(rsp_ok), 64'd0);
    chk("R1", "fault", 64'(rsp_fault), 64'd0);
    look(64'h0, 8'h00, 1'b0);
    expect_rsp("R1", 1'b0, 1'b0, '0, 3'd3);
    step();
    chk("R2", "idle valid", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_small_pages();
    // slot 0: 4 KB pages at 0x12346000 pair, identifier 5
    put_wr(0, 2'b00, 27'h91A3, 8'h05, 1'b0, 12'h000,
           24'h000ABC, 1'b1, 1'b1, 24'h000DEF, 1'b1, 1'b0);
    step();
    look(64'h12346123, 8'h05, 1'b0);
    expect_rsp("R3 even read", 1'b1, 1'b1, 36'hABC123, 3'd0);
    look(64'h12347456, 8'h05, 1'b0);
    expect_rsp("R3 odd read R9", 1'b1, 1'b0, 36'hDEF456, 3'd0);
    look(64'h12347456, 8'h05, 1'b1);
    expect_rsp("R9 modify", 1'b0, 1'b0, '0, 3'd5);
    look(64'h12346008, 8'h05, 1'b1);
    expect_rsp("R9 dirty write", 1'b1, 1'b1, 36'hABC008, 3'd0);
    look(64'h12346123, 8'h06, 1'b0);
    expect_rsp("R7 R10 asid miss read", 1'b0, 1'b0, '0, 3'd1);
    look(64'h12346123, 8'h06, 1'b1);
    expect_rsp("R10 miss write", 1'b0, 1'b0, '0, 3'd2);
    look(64'h8000000012346123, 8'h05, 1'b0);
    expect_rsp("R6 region", 1'b0, 1'b0, '0, 3'd1);
  endtask

  task automatic t_global_mid();
    // slot 1: 16 KB pages, region 3, global, odd half invalid
    put_wr(1, 2'b11, 27'h200, 8'h09, 1'b1, 12'h003,
           24'h000100, 1'b1, 1'b1, 24'h000200, 1'b0, 1'b0);
    step();
    look(64'hC000000000402ABC, 8'h03, 1'b0);
    expect_rsp("R7 R4 global 16K", 1'b1, 1'b1, 36'h102ABC, 3'd0);
    look(64'hC000000000406ABC, 8'h03, 1'b0);
    expect_rsp("R8 R3 invalid read", 1'b0, 1'b0, '0, 3'd3);
    look(64'hC000000000406ABC, 8'h03, 1'b1);
    expect_rsp("R8 invalid write", 1'b0, 1'b0, '0, 3'd4);
  endtask

  task automatic t_big_page();
    // slot 2: 16 MB pages
    put_wr(2, 2'b00, 27'h20000, 8'h05, 1'b0, 12'hFFF,
           24'h004000, 1'b1, 1'b1, 24'h008000, 1'b1, 1'b1);
    step();
    look(64'h41234567, 8'h05, 1'b1);
    expect_rsp("R4 16M odd", 1'b1, 1'b1, 36'h8234567, 3'd0);
  endtask

  task automatic t_illegal_mask();
    put_wr(3, 2'b00, 27'h280, 8'h05, 1'b0, 12'h001,
           24'h000333, 1'b1, 1'b1, 24'h000333, 1'b1, 1'b1);
    step();
    look(64'h500123, 8'h05, 1'b0);
    expect_rsp("R5 illegal mask", 1'b0, 1'b0, '0, 3'd1);
  endtask

  task automatic t_priority_and_timing();
    put_wr(4, 2'b00, 27'h300, 8'h05, 1'b0, 12'h000,
           24'h000444, 1'b1, 1'b1, 24'h000444, 1'b1, 1'b1);
    step();
    put_wr(5, 2'b00, 27'h300, 8'h05, 1'b0, 12'h000,
           24'h000555, 1'b1, 1'b1, 24'h000555, 1'b1, 1'b1);
    step();
    look(64'h600010, 8'h05, 1'b0);
    expect_rsp("R11 start at last", 1'b1, 1'b1, 36'h555010, 3'd0);
    // write slot 3 legal in the same cycle as a lookup of its address
    put_wr(3, 2'b00, 27'h280, 8'h05, 1'b0, 12'h000,
           24'h000333, 1'b1, 1'b1, 24'h000333, 1'b1, 1'b1);
    put_req(64'h500123, 8'h05, 1'b0);
    step();
    expect_rsp("R2 same-cycle write unseen", 1'b0, 1'b0, '0, 3'd1);
    look(64'h500123, 8'h05, 1'b0);
    expect_rsp("R2 write seen next", 1'b1, 1'b1, 36'h333123, 3'd0);
    look(64'h600010, 8'h05, 1'b0);
    expect_rsp("R11 order from 3", 1'b1, 1'b1, 36'h444010, 3'd0);
    put_wr(0, 2'b00, 27'h300, 8'h05, 1'b0, 12'h000,
           24'h000111, 1'b1, 1'b1, 24'h000111, 1'b1, 1'b1);
    step();
    look(64'h600010, 8'h05, 1'b0);
    expect_rsp("R11 order from 0", 1'b1, 1'b1, 36'h111010, 3'd0);
    put_wr(5, 2'b00, 27'h999, 8'h05, 1'b0, 12'h000,
           24'h000555, 1'b1, 1'b1, 24'h000555, 1'b1, 1'b1);
    step();
    look(64'h600010, 8'h05, 1'b0);
    expect_rsp("R11 wrap 5 to 0", 1'b1, 1'b1, 36'h111010, 3'd0);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_small_pages();
    t_global_mid();
    t_big_page();
    t_illegal_mask();
    t_priority_and_timing();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule